// File: doc/BRIEF.md
# Flash Completion Status Poller

This block drives a byte-wide parallel flash from the host side. On a start request it writes the unlock-and-command bus cycles for either a byte program or a sector erase. It then reads the flash repeatedly and decides from the status bits when the internal operation has finished. Two detection methods are available, and the caller picks one with each request. In data-bar mode the poller compares bit 7 of each read against the value it expects. In toggle mode it watches bit 6 and looks for two reads in a row that agree.

After the status bits report completion, the poller does one last full-byte read and returns that byte with a one-cycle done pulse. In data-bar mode it waits a settle interval before that read, because the lower data bits lag behind bit 7. If completion is not seen within a bounded number of status reads, it pulses timeout instead. In both cases it then goes back to idle.

Top module: `fsp_poller`

## Requirements
- R1: While reset is asserted and after its release with no request, `fl_we_n` and `fl_oe_n` are 1, and `done` and `timeout` are 0.
- R2: A program request produces exactly four write strobes carrying (0x5555,0xAA), (0x2AAA,0x55), (0x5555,0xA0) and (`addr`,`wdata`), in that order. An erase request produces exactly six strobes carrying (0x5555,0xAA), (0x2AAA,0x55), (0x5555,0x80), (0x5555,0xAA), (0x2AAA,0x55) and (`addr`,0x30), in that order.
- R3: The first status read (`fl_oe_n` low) comes only after the last write strobe has risen again, at least two clocks after that strobe was low.
- R4: Program with data-bar mode (`use_toggle`=0): a status read counts as complete when its bit 7 equals bit 7 of `wdata`.
- R5: Erase with data-bar mode: a status read counts as complete when its bit 7 is 1.
- R6: Toggle mode (`use_toggle`=1): the operation counts as complete on the first status read whose bit 6 equals bit 6 of the status read just before it. The final read then follows on the second clock after that read, with no settle wait.
- R7: In data-bar mode, at least SETTLE_CYC clocks pass between the completing status read and the final full-byte read. `rd_data` holds the byte from the final read when `done` pulses.
- R8: If MAX_POLLS status reads all fail to show completion, `timeout` pulses and no final read is made. Completion seen on read number MAX_POLLS still ends in `done`.
- R9: `done` and `timeout` are single-cycle pulses and are never high together. After either pulse a new request is accepted.
- R10: `start` is ignored while an operation is in progress. The operation type, mode, address and data are captured in the cycle the request is accepted.
- R11: `fl_we_n` is never low in a cycle where `fl_oe_n` is low, and each write strobe is low for exactly one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a new operation (accepted when idle) |
| op_erase | input | 1 | 1 = sector erase, 0 = byte program |
| use_toggle | input | 1 | 1 = bit-6 toggle detection, 0 = bit-7 data-bar detection |
| addr | input | AW | Target byte address or sector address |
| wdata | input | 8 | Byte to program (expected value) |
| fl_addr | output | AW | Flash address bus |
| fl_dout | output | 8 | Data driven to the flash during writes |
| fl_din | input | 8 | Data read from the flash |
| fl_we_n | output | 1 | Flash write strobe, active low |
| fl_oe_n | output | 1 | Flash read enable, active low |
| done | output | 1 | One-cycle pulse: operation finished |
| timeout | output | 1 | One-cycle pulse: completion not seen in time |
| rd_data | output | 8 | Byte returned by the final confirming read |

## Verification
The hardest case to bring about is the interval right after bit 7 turns true, when the other data bits are still wrong. The bench's flash model returns the true bit 7 with inverted lower bits until SETTLE_CYC clocks have passed since the first non-busy read, so a final read made too early returns a visibly wrong byte. Toggle-mode completion depends on how the last busy toggle value lines up with the final bit 6. The bench therefore sets busy lengths and data bytes that cover both alignments, and it predicts the exact read count for each. The timeout edge is exercised with completion on exactly the last allowed read and with completion that never arrives.

// File: rtl/fsp_pkg.sv
package fsp_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_RD,
    ST_EVAL,
    ST_SETTLE,
    ST_FINAL,
    ST_DONE,
    ST_TOUT
  } fsp_state_e;

  // address selector for a command bus cycle
  typedef enum logic [1:0] {
    AS_UNLK_A,
    AS_UNLK_B,
    AS_TARGET
  } fsp_asel_e;

  localparam logic [15:0] UNLK_ADDR_A = 16'h5555;
  localparam logic [15:0] UNLK_ADDR_B = 16'h2AAA;

  localparam logic [2:0] PROG_LAST  = 3'd3;
  localparam logic [2:0] ERASE_LAST = 3'd5;

  function automatic fsp_asel_e cmd_asel(input logic erase, input logic [2:0] idx);
    fsp_asel_e r;
    if (erase) begin
      case (idx)
        3'd0, 3'd2, 3'd3: r = AS_UNLK_A;
        3'd1, 3'd4:       r = AS_UNLK_B;
        default:          r = AS_TARGET;
      endcase
    end else begin
      case (idx)
        3'd0, 3'd2: r = AS_UNLK_A;
        3'd1:       r = AS_UNLK_B;
        default:    r = AS_TARGET;
      endcase
    end
    return r;
  endfunction

  function automatic logic [7:0] cmd_byte(input logic erase, input logic [2:0] idx,
                                          input logic [7:0] wdata);
    logic [7:0] r;
    if (erase) begin
      case (idx)
        3'd0, 3'd3: r = 8'hAA;
        3'd1, 3'd4: r = 8'h55;
        3'd2:       r = 8'h80;
        default:    r = 8'h30;
      endcase
    end else begin
      case (idx)
        3'd0:    r = 8'hAA;
        3'd1:    r = 8'h55;
        3'd2:    r = 8'hA0;
        default: r = wdata;
      endcase
    end
    return r;
  endfunction

endpackage

// File: rtl/fsp_rst_sync.sv
module fsp_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_n_sync = sync_q[1];

endmodule

// File: rtl/fsp_cmd_seq.sv
module fsp_cmd_seq
  import fsp_pkg::*;
#(
  parameter int AW = 17
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic          erase,
  input  logic [AW-1:0] tgt_addr,
  input  logic [7:0]    wdata,
  output logic          we_n,
  output logic [AW-1:0] bus_addr,
  output logic [7:0]    bus_data,
  output logic          fin
);

  logic       act_q, act_d;
  logic       ph_q, ph_d;
  logic [2:0] idx_q, idx_d;
  logic [2:0] last_idx;
  logic       step_en;
  fsp_asel_e  asel;

  assign last_idx = erase ? ERASE_LAST : PROG_LAST;
  assign step_en  = go | act_q;

  always_comb begin
    act_d = act_q;
    ph_d  = ph_q;
    idx_d = idx_q;
    fin   = 1'b0;
    if (go) begin
      act_d = 1'b1;
      ph_d  = 1'b0;
      idx_d = 3'd0;
    end else if (act_q) begin
      if (!ph_q) begin
        ph_d = 1'b1;
      end else if (idx_q == last_idx) begin
        act_d = 1'b0;
        ph_d  = 1'b0;
        fin   = 1'b1;
      end else begin
        ph_d  = 1'b0;
        idx_d = idx_q + 3'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      ph_q  <= 1'b0;
      idx_q <= 3'd0;
    end else if (step_en) begin
      act_q <= act_d;
      ph_q  <= ph_d;
      idx_q <= idx_d;
    end
  end

  assign we_n = ~(act_q & ~ph_q);
  assign asel = cmd_asel(erase, idx_q);

  always_comb begin
    case (asel)
      AS_UNLK_A: bus_addr = AW'(UNLK_ADDR_A);
      AS_UNLK_B: bus_addr = AW'(UNLK_ADDR_B);
      default:   bus_addr = tgt_addr;
    endcase
  end

  assign bus_data = cmd_byte(erase, idx_q, wdata);

endmodule

// File: rtl/fsp_status_eval.sv
module fsp_status_eval (
  input  logic       use_toggle,
  input  logic       erase,
  input  logic       exp_bit7,
  input  logic [7:0] status,
  input  logic       prev_bit6,
  input  logic       have_prev,
  output logic       complete
);

  logic dbar_ok;
  logic tog_ok;

  assign dbar_ok  = erase ? status[7] : (status[7] == exp_bit7);
  assign tog_ok   = have_prev & (status[6] == prev_bit6);
  assign complete = use_toggle ? tog_ok : dbar_ok;

endmodule

// File: rtl/fsp_cnt_dn.sv
module fsp_cnt_dn #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         last
);

  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  assign cnt_en = load | dec;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = load_val;
    end else if (dec && cnt_q != '0) begin
      cnt_d = cnt_q - W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign last = (cnt_q == W'(1));

endmodule

// File: rtl/fsp_poller.sv
module fsp_poller
  import fsp_pkg::*;
#(
  parameter int AW         = 17,
  parameter int SETTLE_CYC = 250,
  parameter int MAX_POLLS  = 1024
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          op_erase,
  input  logic          use_toggle,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [AW-1:0] fl_addr,
  output logic [7:0]    fl_dout,
  input  logic [7:0]    fl_din,
  output logic          fl_we_n,
  output logic          fl_oe_n,
  output logic          done,
  output logic          timeout,
  output logic [7:0]    rd_data
);

  localparam int PCW = $clog2(MAX_POLLS + 1);
  localparam int SCW = $clog2(SETTLE_CYC + 1);

  logic          rst_n_i;
  fsp_state_e    st_q, st_d;
  logic          erase_q, tog_q;
  logic [AW-1:0] addr_q;
  logic [7:0]    wdat_q;
  logic [7:0]    samp_q;
  logic          prev6_q, prev6_d;
  logic          hprev_q, hprev_d;
  logic [PCW-1:0] pcnt_q, pcnt_d;
  logic [7:0]    data_q;

  logic          accept;
  logic          samp_en, data_en, hist_en, pcnt_en;
  logic          seq_fin, seq_we_n;
  logic [AW-1:0] seq_addr;
  logic [7:0]    seq_dout;
  logic          complete;
  logic          tmr_load, tmr_dec, tmr_last;

  fsp_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  fsp_cmd_seq #(.AW(AW)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .go       (accept),
    .erase    (accept ? op_erase : erase_q),
    .tgt_addr (addr_q),
    .wdata    (wdat_q),
    .we_n     (seq_we_n),
    .bus_addr (seq_addr),
    .bus_data (seq_dout),
    .fin      (seq_fin)
  );

  fsp_status_eval u_eval (
    .use_toggle (tog_q),
    .erase      (erase_q),
    .exp_bit7   (wdat_q[7]),
    .status     (samp_q),
    .prev_bit6  (prev6_q),
    .have_prev  (hprev_q),
    .complete   (complete)
  );

  fsp_cnt_dn #(.W(SCW)) u_settle (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .load     (tmr_load),
    .load_val (SCW'(SETTLE_CYC)),
    .dec      (tmr_dec),
    .last     (tmr_last)
  );

  assign accept  = (st_q == ST_IDLE) & start;
  assign samp_en = (st_q == ST_RD);
  assign data_en = (st_q == ST_FINAL);

  // next-state logic
  always_comb begin
    st_d     = st_q;
    prev6_d  = prev6_q;
    hprev_d  = hprev_q;
    pcnt_d   = pcnt_q;
    hist_en  = 1'b0;
    pcnt_en  = 1'b0;
    tmr_load = 1'b0;
    tmr_dec  = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start) st_d = ST_CMD;
      end
      ST_CMD: begin
        if (seq_fin) begin
          st_d    = ST_RD;
          pcnt_d  = '0;
          pcnt_en = 1'b1;
          hprev_d = 1'b0;
          hist_en = 1'b1;
        end
      end
      ST_RD: begin
        pcnt_d  = pcnt_q + PCW'(1);
        pcnt_en = 1'b1;
        st_d    = ST_EVAL;
      end
      ST_EVAL: begin
        if (complete) begin
          if (tog_q) begin
            st_d = ST_FINAL;
          end else begin
            st_d     = ST_SETTLE;
            tmr_load = 1'b1;
          end
        end else if (pcnt_q == PCW'(MAX_POLLS)) begin
          st_d = ST_TOUT;
        end else begin
          st_d    = ST_RD;
          prev6_d = samp_q[6];
          hprev_d = 1'b1;
          hist_en = 1'b1;
        end
      end
      ST_SETTLE: begin
        tmr_dec = 1'b1;
        if (tmr_last) st_d = ST_FINAL;
      end
      ST_FINAL: st_d = ST_DONE;
      ST_DONE:  st_d = ST_IDLE;
      ST_TOUT:  st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  // state register
  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      st_q <= ST_IDLE;
    end else begin
      st_q <= st_d;
    end
  end

  // request capture
  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      erase_q <= 1'b0;
      tog_q   <= 1'b0;
      addr_q  <= '0;
      wdat_q  <= '0;
    end else if (accept) begin
      erase_q <= op_erase;
      tog_q   <= use_toggle;
      addr_q  <= addr;
      wdat_q  <= wdata;
    end
  end

  // status sample and history
  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      samp_q  <= '0;
    end else if (samp_en) begin
      samp_q  <= fl_din;
    end
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      prev6_q <= 1'b0;
      hprev_q <= 1'b0;
    end else if (hist_en) begin
      prev6_q <= prev6_d;
      hprev_q <= hprev_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      pcnt_q <= '0;
    end else if (pcnt_en) begin
      pcnt_q <= pcnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      data_q <= '0;
    end else if (data_en) begin
      data_q <= fl_din;
    end
  end

  assign fl_we_n = (st_q == ST_CMD) ? seq_we_n : 1'b1;
  assign fl_oe_n = ~((st_q == ST_RD) | (st_q == ST_FINAL));
  assign fl_addr = (st_q == ST_CMD) ? seq_addr : addr_q;
  assign fl_dout = seq_dout;
  assign done    = (st_q == ST_DONE);
  assign timeout = (st_q == ST_TOUT);
  assign rd_data = data_q;

endmodule

// File: rtl/fsp_poller_chk.sv
module fsp_poller_chk (
  input logic clk,
  input logic rst_n,
  input logic done,
  input logic timeout,
  input logic fl_we_n,
  input logic fl_oe_n
);

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R9
  AST_TOUT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) timeout |=> !timeout); // R9
  AST_END_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n) !(done && timeout)); // R9
  AST_BUS_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n) !(!fl_we_n && !fl_oe_n)); // R11
  AST_WE_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n) !fl_we_n |=> fl_we_n); // R11
  AST_DONE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n) $rose(done) |-> $past(!fl_oe_n)); // R7
  AST_TOUT_NO_FINAL: assert property (@(posedge clk) disable iff (!rst_n) $rose(timeout) |-> $past(fl_oe_n)); // R8

endmodule

bind fsp_poller fsp_poller_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .done    (done),
  .timeout (timeout),
  .fl_we_n (fl_we_n),
  .fl_oe_n (fl_oe_n)
);

// File: tb/fsp_poller_test.sv
module fsp_poller_test;

  localparam int AW = 17;
  localparam int S  = 20;
  localparam int M  = 16;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n, start, op_erase, use_toggle;
  logic [AW-1:0] addr;
  logic [7:0]    wdata;
  logic [AW-1:0] fl_addr;
  logic [7:0]    fl_dout, fl_din, rd_data;
  logic          fl_we_n, fl_oe_n, done, timeout;

  fsp_poller #(.AW(AW), .SETTLE_CYC(S), .MAX_POLLS(M)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_erase(op_erase),
    .use_toggle(use_toggle), .addr(addr), .wdata(wdata),
    .fl_addr(fl_addr), .fl_dout(fl_dout), .fl_din(fl_din),
    .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n), .done(done),
    .timeout(timeout), .rd_data(rd_data)
  );

  int n_tests = 0;
  int n_fail  = 0;

  // flash model controls
  bit         m_clear = 0;
  bit         m_erase = 0;
  bit         m_garb  = 0;
  int         m_busy  = 0;
  logic [7:0] m_byte  = 8'h00;

  // flash model state
  int            cyc = 0;
  int            writes = 0, reads = 0, busy_left = 0, t_true = -1;
  int            first_rd_writes = -1, first_rd_cyc = 0, last_wr_cyc = 0;
  int            rd_prev_cyc = 0, rd_last_cyc = 0;
  bit            tog = 0, overlap = 0;
  logic [AW-1:0] wa [6];
  logic [7:0]    wd [6];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (m_clear) begin
      writes <= 0; reads <= 0; busy_left <= m_busy; tog <= 0; t_true <= -1;
      first_rd_writes <= -1; overlap <= 0;
    end else begin
      if (!fl_we_n && !fl_oe_n) overlap <= 1;
      if (!fl_we_n) begin
        if (writes < 6) begin
          wa[writes] <= fl_addr;
          wd[writes] <= fl_dout;
        end
        writes <= writes + 1;
        last_wr_cyc <= cyc;
      end
      if (!fl_oe_n) begin
        reads <= reads + 1;
        if (reads == 0) begin
          first_rd_writes <= writes;
          first_rd_cyc <= cyc;
        end
        rd_prev_cyc <= rd_last_cyc;
        rd_last_cyc <= cyc;
        if (busy_left > 0) begin
          busy_left <= busy_left - 1;
          tog <= ~tog;
        end else if (t_true < 0) begin
          t_true <= cyc;
        end
      end
    end
  end

  always_comb begin
    if (busy_left > 0)
      fl_din = {(m_erase ? 1'b0 : ~m_byte[7]), tog, 6'b101010};
    else if (m_garb && (t_true < 0 || (cyc - t_true) < S))
      fl_din = {m_byte[7], ~m_byte[6:0]};
    else
      fl_din = m_byte;
  end

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic int toggle_reads(input int k, input logic d6);
    int n;
    if (k == 0) n = 2;
    else if (((k - 1) & 1) == int'(d6)) n = k + 1;
    else n = k + 2;
    return n;
  endfunction

  task automatic issue(input logic er, input logic tg, input logic [AW-1:0] a,
                       input logic [7:0] d, input int k, input bit garb);
    @(negedge clk);
    m_erase = er; m_byte = er ? 8'hFF : d; m_busy = k; m_garb = garb; m_clear = 1;
    @(negedge clk);
    m_clear = 0;
    start = 1; op_erase = er; use_toggle = tg; addr = a; wdata = d;
    @(negedge clk);
    // R10: change inputs right after acceptance
    start = 0; op_erase = ~er; use_toggle = ~tg; addr = ~a; wdata = ~d;
  endtask

  task automatic finish_op(output bit got_done, output bit got_to, output logic [7:0] rdv);
    got_done = 0; got_to = 0; rdv = 8'h00;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (done || timeout) begin
        got_done = done; got_to = timeout; rdv = rd_data;
        break;
      end
    end
    if (!got_done && !got_to) begin
      n_tests++; n_fail++;
      $display("FAIL R9 end of operation: actual none expected done or timeout");
    end
    @(negedge clk);
    chk("R9", "done width", done, 0);
    chk("R9", "timeout width", timeout, 0);
  endtask

  task automatic t_reset();
    rst_n = 0; start = 0; op_erase = 0; use_toggle = 0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    chk("R1", "we_n in reset", fl_we_n, 1);
    chk("R1", "oe_n in reset", fl_oe_n, 1);
    chk("R1", "done in reset", done, 0);
    chk("R1", "timeout in reset", timeout, 0);
    rst_n = 1;
    repeat (5) @(negedge clk);
    chk("R1", "we_n idle", fl_we_n, 1);
    chk("R1", "oe_n idle", fl_oe_n, 1);
    chk("R1", "done idle", done, 0);
  endtask

  task automatic t_prog_dq7(input logic [7:0] d, input int k);
    bit gd, gt; logic [7:0] rv;
    issue(1'b0, 1'b0, 17'h1_2345, d, k, 1'b1);
    finish_op(gd, gt, rv);
    chk("R4", "program done", gd, 1);
    chk("R4", "poll reads", reads, k + 2);
    chk("R2", "write count", writes, 4);
    chk("R2", "w0 data", wd[0], 8'hAA);
    chk("R2", "w1 addr", wa[1], 17'h2AAA);
    chk("R2", "w2 data", wd[2], 8'hA0);
    chk("R2", "w3 addr", wa[3], 17'h1_2345);
    chk("R2", "w3 data", wd[3], d);
    chk("R3", "writes before first read", first_rd_writes, 4);
    chk("R3", "read after strobe rise", (first_rd_cyc - last_wr_cyc) >= 2, 1);
    chk("R7", "settle gap", (rd_last_cyc - rd_prev_cyc) >= S, 1);
    chk("R7", "final byte", rv, d);
    chk("R11", "no bus overlap", overlap, 0);
  endtask

  task automatic t_erase_dq7(input int k);
    bit gd, gt; logic [7:0] rv;
    issue(1'b1, 1'b0, 17'h0_3000, 8'h12, k, 1'b1);
    finish_op(gd, gt, rv);
    chk("R5", "erase done", gd, 1);
    chk("R5", "poll reads", reads, k + 2);
    chk("R2", "erase writes", writes, 6);
    chk("R2", "e2 data", wd[2], 8'h80);
    chk("R2", "e3 data", wd[3], 8'hAA);
    chk("R2", "e4 addr", wa[4], 17'h2AAA);
    chk("R2", "e5 addr", wa[5], 17'h0_3000);
    chk("R2", "e5 data", wd[5], 8'h30);
    chk("R3", "writes before first read", first_rd_writes, 6);
    chk("R7", "erased byte", rv, 8'hFF);
  endtask

  task automatic t_toggle(input logic er, input logic [7:0] d, input int k);
    bit gd, gt; logic [7:0] rv; logic [7:0] exp_b;
    exp_b = er ? 8'hFF : d;
    issue(er, 1'b1, 17'h0_0777, d, k, 1'b0);
    finish_op(gd, gt, rv);
    chk("R6", "toggle done", gd, 1);
    chk("R6", "toggle reads", reads, toggle_reads(k, exp_b[6]) + 1);
    chk("R6", "no settle wait", rd_last_cyc - rd_prev_cyc, 2);
    chk("R6", "toggle final byte", rv, exp_b);
  endtask

  task automatic t_timeout();
    bit gd, gt; logic [7:0] rv;
    issue(1'b0, 1'b0, 17'h0_0100, 8'h00, M + 5, 1'b0);
    finish_op(gd, gt, rv);
    chk("R8", "timeout flagged", gt, 1);
    chk("R8", "no done", gd, 0);
    chk("R8", "reads without final", reads, M);
  endtask

  task automatic t_boundary();
    bit gd, gt; logic [7:0] rv;
    issue(1'b0, 1'b0, 17'h0_0200, 8'h81, M - 1, 1'b1);
    finish_op(gd, gt, rv);
    chk("R8", "last-read completion done", gd, 1);
    chk("R8", "last-read completion no timeout", gt, 0);
    chk("R8", "reads", reads, M + 1);
    chk("R8", "byte", rv, 8'h81);
  endtask

  task automatic t_ignore_start();
    bit gd, gt; logic [7:0] rv;
    issue(1'b0, 1'b0, 17'h0_0400, 8'h5C, 6, 1'b1);
    repeat (3) @(negedge clk);
    start = 1; op_erase = 1; use_toggle = 1; addr = 17'h1_FFFF; wdata = 8'hEE;
    @(negedge clk); start = 0;
    repeat (12) @(negedge clk);
    start = 1;
    @(negedge clk); start = 0;
    finish_op(gd, gt, rv);
    chk("R10", "done of first op", gd, 1);
    chk("R10", "writes unchanged", writes, 4);
    chk("R10", "target kept", wa[3], 17'h0_0400);
    chk("R10", "byte kept", rv, 8'h5C);
    chk("R10", "reads of first op", reads, 8);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_prog_dq7(8'h3C, 5);
    t_prog_dq7(8'hA7, 0);
    t_erase_dq7(7);
    t_toggle(1'b0, 8'h3C, 5);
    t_toggle(1'b0, 8'hC3, 5);
    t_toggle(1'b1, 8'h00, 4);
    t_timeout();
    t_boundary();
    t_ignore_start();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule